// File: doc/BRIEF.md
# Serial Volume-Setting Receiver

This block is the receiving end of a two-wire setting port used to program a four-channel analog volume stage (two surround channels, centre, and low-frequency effects). A host drives a serial clock and a data line. Both are slow next to the system clock and asynchronous to it. The block synchronises the two lines, builds a 16-bit word least-significant bit first, and commits the word to one of four setting registers. The commit happens only when a latch condition follows exactly sixteen bits. The latch condition is the data line being high at a falling serial-clock edge. The two top bits of the word pick the register.

The stored registers are decoded into named control fields: a trim code and a master code per channel, an input gain select, an output gain select, bass boost, and four routing switches. The block also computes a total attenuation in dB for each channel, which saturates at the 87 dB floor. The master code 31 is decoded as a mute flag.

After reset, every setting takes its default value. The port ignores all serial traffic for a programmable hold window.

Top module: `volctl_serial_rx`

## Requirements
- R1: After reset, the settings are:
  - all trims 0;
  - all master codes 31, with every mute flag set and every attenuation 87;
  - the SW mix switch off (`sw_mix_off`=1) and every other switch 0;
  - both gain selects 0;
  - no update pulse.
- R2: A data bit is taken at each rising serial-clock edge. The first bit received becomes bit 0 of the word.
- R3: A falling serial-clock edge with the data line high is a latch condition, and it commits the word only after exactly 16 bits. A falling edge with the data line low changes nothing. The latch condition counts as such even when the data line rises in the same system cycle as the clock falls.
- R4: The register index is {D14,D15}:
  - 0 holds the surround trims and input controls;
  - 1 holds the centre/LFE trims and output controls;
  - 2 holds the surround master codes;
  - 3 holds the centre/LFE master codes.
  Bits D13..D0 are stored as the payload.
- R5: A latch condition that follows fewer or more than 16 bits discards the frame and leaves every register unchanged. Any latch condition restarts the bit count.
- R6: Register 0 field layout:
  - surround-left trim is D3..D0;
  - surround-right trim is D7..D4;
  - input gain select is {D8,D9};
  - front output off is D10;
  - external surround source is D11;
  - LFE mix off is D12;
  - SW mix off is D13.
- R7: Register 1 field layout:
  - centre trim is D3..D0;
  - LFE trim is D7..D4;
  - bass boost is D8;
  - output gain select is {D9,D10}, where 0, 1, 2 and 3 give 0, +6, +9 and +12 dB.
- R8: Register 2 holds surround-left in D4..D0 and surround-right in D9..D5, and register 3 holds centre in D4..D0 and LFE in D9..D5.
  - Master codes 0 to 22 attenuate by 2 dB per step.
  - Codes 23 to 30 attenuate by 48 + 4·(code−23) dB.
  - Code 31 sets mute and reports 87.
  - A channel's attenuation is its trim plus its master attenuation, capped at 87.
- R9: Each commit produces a single-cycle, one-hot update pulse on the bit of the register written.
- R10: For HOLD_CYC system cycles after reset, latch conditions commit nothing and produce no pulse.
- R11: Input gain in dB is 10 when D8 is set, otherwise 5 when D9 is set, otherwise 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial clock line, asynchronous |
| ser_dat | input | 1 | Serial data line, asynchronous |
| trim_codes | output | 16 | Trim codes, 4 bits per channel (SL, SR, C, LFE from LSB) |
| master_codes | output | 20 | Master codes, 5 bits per channel |
| att_db | output | 28 | Total attenuation per channel, 7 bits each |
| mute | output | 4 | Per-channel mute (master code 31) |
| in_gain_sel | output | 2 | Input gain select {D8,D9} of register 0 |
| in_gain_db | output | 4 | Input gain in dB |
| front_out_off | output | 1 | Front output switch off |
| surr_ext_sel | output | 1 | Surround volume fed from external input |
| lfe_mix_off | output | 1 | LFE mix switch off |
| sw_mix_off | output | 1 | SW mix switch off |
| bass_boost_on | output | 1 | Bass boost enable |
| out_gain_sel | output | 2 | Output gain select {D9,D10} of register 1 |
| out_gain_db | output | 4 | Output gain in dB |
| upd_pulse | output | 4 | One-cycle pulse per register written |

## Verification
Two events can fall in the same system cycle: the rise of the data line that forms the latch condition and the fall of the serial clock. Both lines pass through synchronisers of equal depth, so a simultaneous host-side change reaches the edge detector together. The bench provokes this by changing both lines at the same instant on the final bit of a frame. The result is judged by the update pulse and by the decoded fields matching the word. A second case covers sixteen bits left unlatched followed by a full frame. That frame overruns the count, and the bench checks that it is discarded without any pulse.

// File: rtl/volctl_pkg.sv
`timescale 1ns/1ps
package volctl_pkg;
  localparam int WORD_W    = 16;
  localparam int NREG      = 4;
  localparam int PAY_W     = 14;
  localparam int NCH       = 4;
  localparam int TRIM_W    = 4;
  localparam int MVOL_W    = 5;
  localparam int ATT_W     = 7;
  localparam int ATT_FLOOR = 87;
  localparam int MUTE_CODE = 31;

  // reset value of each setting register
  function automatic logic [PAY_W-1:0] reg_default(input int idx);
    case (idx)
      0:       return 14'h2000;   // SW mix off
      1:       return 14'h0000;
      default: return 14'h03FF;   // both master codes muted
    endcase
  endfunction

  // master code to dB of attenuation (code 31 handled by caller)
  function automatic logic [ATT_W-1:0] master_db(input logic [MVOL_W-1:0] code);
    int v;
    if (code < 5'd23) v = 2 * int'(code);
    else              v = 48 + 4 * (int'(code) - 23);
    return ATT_W'(v);
  endfunction

  function automatic logic [ATT_W-1:0] att_total(input logic [TRIM_W-1:0] trim,
                                                 input logic [MVOL_W-1:0] code);
    int s;
    if (int'(code) == MUTE_CODE) return ATT_W'(ATT_FLOOR);
    s = int'(trim) + int'(master_db(code));
    if (s > ATT_FLOOR) s = ATT_FLOOR;
    return ATT_W'(s);
  endfunction

  // sel = {D8,D9}
  function automatic logic [3:0] in_gain_db(input logic [1:0] sel);
    if (sel[1])      return 4'd10;
    else if (sel[0]) return 4'd5;
    return 4'd0;
  endfunction

  // sel = {D9,D10}
  function automatic logic [3:0] out_gain_db(input logic [1:0] sel);
    case (sel)
      2'd0:    return 4'd0;
      2'd1:    return 4'd6;
      2'd2:    return 4'd9;
      default: return 4'd12;
    endcase
  endfunction
endpackage

// File: rtl/volctl_sync.sv
`timescale 1ns/1ps
module volctl_sync #(
  parameter int N      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] async_in,
  output logic [N-1:0] lvl,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);
  // STAGES synchroniser flops plus one history flop
  logic [STAGES:0][N-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-1:0], async_in};
  end

  assign lvl  = chain[STAGES-1];
  assign rise = chain[STAGES-1] & ~chain[STAGES];
  assign fall = ~chain[STAGES-1] & chain[STAGES];
endmodule

// File: rtl/volctl_shift.sv
`timescale 1ns/1ps
module volctl_shift #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         rise,
  input  logic         fall,
  input  logic         din,
  output logic [W-1:0] word,
  output logic         commit,
  output logic         drop
);
  localparam int CW   = $clog2(W + 2);
  localparam int CMAX = (1 << CW) - 1;

  logic [W-1:0]  sh;
  logic [CW-1:0] cnt;
  logic          latch_evt;

  assign latch_evt = en & fall & din;
  assign commit    = latch_evt & (cnt == CW'(W));
  assign drop      = latch_evt & (cnt != CW'(W));
  assign word      = sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh  <= '0;
      cnt <= '0;
    end else if (!en) begin
      cnt <= '0;
    end else if (latch_evt) begin
      cnt <= '0;
    end else if (rise) begin
      sh  <= {din, sh[W-1:1]};
      cnt <= (cnt == CW'(CMAX)) ? cnt : cnt + 1'b1;
    end
  end

  // R5: any latch condition restarts the count
  a_r5_cnt_clear: assert property (@(posedge clk) disable iff (!rst_n)
    latch_evt |=> (cnt == '0));
  // R2: each accepted rising edge advances the count by one
  a_r2_cnt_step: assert property (@(posedge clk) disable iff (!rst_n)
    (en && rise && !latch_evt && cnt != CW'(CMAX)) |=> (cnt == $past(cnt) + 1'b1));
  // R3: commit and drop never coincide
  a_r3_commit_xor_drop: assert property (@(posedge clk) disable iff (!rst_n)
    !(commit && drop));
endmodule

// File: rtl/volctl_bank.sv
`timescale 1ns/1ps
module volctl_bank
  import volctl_pkg::*;
#(
  parameter int W  = WORD_W,
  parameter int NR = NREG,
  parameter int PW = PAY_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr,
  input  logic [W-1:0]          word,
  output logic [NR-1:0][PW-1:0] bank,
  output logic [NR-1:0]         upd
);
  localparam int SEL_W = $clog2(NR);

  logic [SEL_W-1:0] sel;

  // index bit b comes from word bit W-1-b, so the index is {D14,D15}
  for (genvar b = 0; b < SEL_W; b++) begin : g_sel
    assign sel[b] = word[W-1-b];
  end

  for (genvar r = 0; r < NR; r++) begin : g_reg
    logic hit;
    assign hit = wr && (sel == SEL_W'(r));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        bank[r] <= reg_default(r);
        upd[r]  <= 1'b0;
      end else begin
        upd[r] <= hit;
        if (hit) bank[r] <= word[PW-1:0];
      end
    end

    // R4: the pulsed register now holds the committed payload
    a_r4_target_loaded: assert property (@(posedge clk) disable iff (!rst_n)
      upd[r] |-> (bank[r] == $past(word[PW-1:0])));
  end

  // R9: at most one register reports an update
  a_r9_upd_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(upd));
  // R5: no write leaves the bank untouched
  a_r5_bank_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(bank));
endmodule

// File: rtl/volctl_serial_rx.sv
`timescale 1ns/1ps
module volctl_serial_rx
  import volctl_pkg::*;
#(
  parameter int HOLD_CYC    = 1000,
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ser_clk,
  input  logic                    ser_dat,
  output logic [NCH*TRIM_W-1:0]   trim_codes,
  output logic [NCH*MVOL_W-1:0]   master_codes,
  output logic [NCH*ATT_W-1:0]    att_db,
  output logic [NCH-1:0]          mute,
  output logic [1:0]              in_gain_sel,
  output logic [3:0]              in_gain_db,
  output logic                    front_out_off,
  output logic                    surr_ext_sel,
  output logic                    lfe_mix_off,
  output logic                    sw_mix_off,
  output logic                    bass_boost_on,
  output logic [1:0]              out_gain_sel,
  output logic [3:0]              out_gain_db,
  output logic [NREG-1:0]         upd_pulse
);
  localparam int HW = $clog2(HOLD_CYC + 2);

  // power-on hold window
  logic [HW-1:0] hold_cnt;
  logic          ready;
  assign ready = (hold_cnt == HW'(HOLD_CYC));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      hold_cnt <= '0;
    else if (!ready) hold_cnt <= hold_cnt + 1'b1;
  end

  // line synchronisers: bit 0 serial clock, bit 1 serial data
  logic [1:0] s_lvl, s_rise, s_fall;
  volctl_sync #(.N(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in({ser_dat, ser_clk}),
    .lvl(s_lvl), .rise(s_rise), .fall(s_fall));

  logic              unused_edges;
  assign unused_edges = ^{s_rise[1], s_fall[1], s_lvl[0]};

  logic [WORD_W-1:0] word;
  logic              commit, drop;
  volctl_shift #(.W(WORD_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .en(ready), .rise(s_rise[0]), .fall(s_fall[0]),
    .din(s_lvl[1]), .word(word), .commit(commit), .drop(drop));

  logic unused_drop;
  assign unused_drop = drop;

  logic [NREG-1:0][PAY_W-1:0] bank;
  volctl_bank #(.W(WORD_W), .NR(NREG), .PW(PAY_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr(commit), .word(word), .bank(bank), .upd(upd_pulse));

  // per-channel decode: SL, SR in registers 0/2; C, LFE in registers 1/3
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam int TREG = c / 2;
    localparam int TOFS = TRIM_W * (c % 2);
    localparam int MREG = 2 + c / 2;
    localparam int MOFS = MVOL_W * (c % 2);
    logic [TRIM_W-1:0] t;
    logic [MVOL_W-1:0] m;
    assign t = bank[TREG][TOFS +: TRIM_W];
    assign m = bank[MREG][MOFS +: MVOL_W];
    assign trim_codes[c*TRIM_W +: TRIM_W]   = t;
    assign master_codes[c*MVOL_W +: MVOL_W] = m;
    assign att_db[c*ATT_W +: ATT_W]         = att_total(t, m);
    assign mute[c]                          = (m == MVOL_W'(MUTE_CODE));

    // R8: attenuation never passes the floor, and mute reports the floor
    a_r8_att_cap: assert property (@(posedge clk) disable iff (!rst_n)
      att_db[c*ATT_W +: ATT_W] <= ATT_W'(ATT_FLOOR));
    a_r8_mute_floor: assert property (@(posedge clk) disable iff (!rst_n)
      mute[c] |-> (att_db[c*ATT_W +: ATT_W] == ATT_W'(ATT_FLOOR)));
  end

  assign in_gain_sel   = {bank[0][8], bank[0][9]};
  assign in_gain_db    = volctl_pkg::in_gain_db(in_gain_sel);
  assign front_out_off = bank[0][10];
  assign surr_ext_sel  = bank[0][11];
  assign lfe_mix_off   = bank[0][12];
  assign sw_mix_off    = bank[0][13];
  assign bass_boost_on = bank[1][8];
  assign out_gain_sel  = {bank[1][9], bank[1][10]};
  assign out_gain_db   = volctl_pkg::out_gain_db(out_gain_sel);

  logic unused_rsv;
  assign unused_rsv = ^{bank[1][13:11], bank[2][13:10], bank[3][13:10]};

  // R10: nothing is committed inside the hold window; the window ends once
  a_r10_hold_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> (upd_pulse == '0));
  a_r10_ready_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> ready);
endmodule

// File: tb/test_volctl_serial_rx.sv
`timescale 1ns/1ps
module test_volctl_serial_rx;
  localparam int HOLD = 1000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 1'b0;
  logic ser_dat = 1'b0;
  logic [15:0] trim_codes;
  logic [19:0] master_codes;
  logic [27:0] att_db;
  logic [3:0]  mute, in_gain_db, out_gain_db, upd_pulse;
  logic [1:0]  in_gain_sel, out_gain_sel;
  logic front_out_off, surr_ext_sel, lfe_mix_off, sw_mix_off, bass_boost_on;

  always #10 clk = ~clk;

  volctl_serial_rx #(.HOLD_CYC(HOLD)) i_volctl_serial_rx (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
    .trim_codes(trim_codes), .master_codes(master_codes), .att_db(att_db),
    .mute(mute), .in_gain_sel(in_gain_sel), .in_gain_db(in_gain_db),
    .front_out_off(front_out_off), .surr_ext_sel(surr_ext_sel),
    .lfe_mix_off(lfe_mix_off), .sw_mix_off(sw_mix_off),
    .bass_boost_on(bass_boost_on), .out_gain_sel(out_gain_sel),
    .out_gain_db(out_gain_db), .upd_pulse(upd_pulse));

  int checks = 0;
  int failures = 0;
  int pcount = 0;
  logic [3:0] plast = '0;
  logic [3:0] pprev = '0;
  logic [13:0] shadow [4];

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // R9 monitor: counts pulses and flags any that last two cycles
  always @(negedge clk) begin
    if (rst_n && upd_pulse != 0) begin
      pcount++;
      plast = upd_pulse;
      if (pprev != 0) begin
        checks++; failures++;
        $display("FAIL R9 pulse width actual=2 expected=1");
      end
    end
    pprev = upd_pulse;
  end

  task automatic idle(input int k);
    repeat (k) @(negedge clk);
  endtask

  function automatic int e_trim(input int c);
    case (c)
      0: return int'(shadow[0][3:0]);
      1: return int'(shadow[0][7:4]);
      2: return int'(shadow[1][3:0]);
      default: return int'(shadow[1][7:4]);
    endcase
  endfunction

  function automatic int e_mast(input int c);
    case (c)
      0: return int'(shadow[2][4:0]);
      1: return int'(shadow[2][9:5]);
      2: return int'(shadow[3][4:0]);
      default: return int'(shadow[3][9:5]);
    endcase
  endfunction

  function automatic int e_att(input int c);
    int m, s;
    m = e_mast(c);
    if (m == 31) return 87;
    s = e_trim(c) + m * 2 + ((m > 22) ? (m - 22) * 2 : 0);
    return (s > 87) ? 87 : s;
  endfunction

  task automatic check_all(input string req);
    for (int c = 0; c < 4; c++) begin
      chk({req, " R6/R7 trim"}, int'(trim_codes[c*4 +: 4]), e_trim(c));
      chk({req, " R8 master"}, int'(master_codes[c*5 +: 5]), e_mast(c));
      chk({req, " R8 att"}, int'(att_db[c*7 +: 7]), e_att(c));
      chk({req, " R8 mute"}, int'(mute[c]), int'(e_mast(c) == 31));
    end
    chk({req, " R6 in_sel"}, int'(in_gain_sel), int'({shadow[0][8], shadow[0][9]}));
    chk({req, " R11 in_db"}, int'(in_gain_db),
        shadow[0][8] ? 10 : (shadow[0][9] ? 5 : 0));
    chk({req, " R6 switches"},
        int'({front_out_off, surr_ext_sel, lfe_mix_off, sw_mix_off}),
        int'(shadow[0][13:10] == 4'b0 ? 4'b0 :
             {shadow[0][10], shadow[0][11], shadow[0][12], shadow[0][13]}));
    chk({req, " R7 bass"}, int'(bass_boost_on), int'(shadow[1][8]));
    chk({req, " R7 out_sel"}, int'(out_gain_sel), int'({shadow[1][9], shadow[1][10]}));
    chk({req, " R7 out_db"}, int'(out_gain_db),
        shadow[1][9] ? (shadow[1][10] ? 12 : 9) : (shadow[1][10] ? 6 : 0));
  endtask

  // n bits LSB first; optional latch on the last fall; same: data and clock move together
  task automatic send(input logic [15:0] w, input int n, input bit latch, input bit same);
    for (int i = 0; i < n; i++) begin
      ser_dat = w[i]; idle(3);
      ser_clk = 1'b1; idle(3);
      if (i == n - 1 && latch) begin
        if (same) begin ser_dat = 1'b1; ser_clk = 1'b0; end
        else begin ser_dat = 1'b1; idle(3); ser_clk = 1'b0; end
      end else begin
        ser_dat = 1'b0; idle(3); ser_clk = 1'b0;
      end
      idle(3);
    end
    ser_dat = 1'b0;
    idle(8);
  endtask

  typedef struct packed { logic [15:0] w; logic [3:0] exp_upd; } vec_t;
  localparam vec_t TBL [9] = '{
    '{16'h16F3, 4'b0001},
    '{16'h8517, 4'b0010},
    '{16'h42DE, 4'b0100},
    '{16'hC3F7, 4'b1000},
    '{16'h290F, 4'b0001},
    '{16'h82F0, 4'b0010},
    '{16'h8600, 4'b0010},
    '{16'h4000, 4'b0100},
    '{16'h0300, 4'b0001}
  };

  bit done = 0;

  initial begin
    #(20 * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int p0;
    shadow[0] = 14'h2000; shadow[1] = 14'h0000;
    shadow[2] = 14'h03FF; shadow[3] = 14'h03FF;
    idle(3);
    rst_n = 1'b1;
    idle(2);
    // R1 reset defaults
    check_all("R1 reset");
    chk("R1 no pulse", pcount, 0);
    chk("R1 sw_mix_off", int'(sw_mix_off), 1);

    // R10 frame inside the hold window is ignored
    send(16'h16F3, 16, 1, 0);
    check_all("R10 hold");
    chk("R10 no pulse", pcount, 0);
    idle(HOLD);

    // table walk: R2 R4 R6 R7 R8 R9 R11
    foreach (TBL[k]) begin
      int idx;
      p0 = pcount;
      send(TBL[k].w, 16, 1, 0);
      idx = {TBL[k].w[14], TBL[k].w[15]};
      shadow[idx] = TBL[k].w[13:0];
      chk("R9 one pulse", pcount - p0, 1);
      chk("R4 target", int'(plast), int'(TBL[k].exp_upd));
      check_all("R2 table");
    end

    // R5 short frame (15 bits)
    p0 = pcount;
    send(16'h4021, 15, 1, 0);
    chk("R5 short no pulse", pcount - p0, 0);
    check_all("R5 short");

    // R5 long frame (17 bits)
    send(16'hC021, 17, 1, 0);
    chk("R5 long no pulse", pcount - p0, 0);
    check_all("R5 long");

    // R3 sixteen bits with data low at every fall: nothing committed
    send(16'h4063, 16, 0, 0);
    chk("R3 no latch no pulse", pcount - p0, 0);
    check_all("R3 no latch");
    // R5 next full frame overruns the count and is discarded
    send(16'h4063, 16, 1, 0);
    chk("R5 overrun no pulse", pcount - p0, 0);
    check_all("R5 overrun");

    // R5 count restarted: a clean frame now lands
    send(16'h4063, 16, 1, 0);
    shadow[2] = 14'h0063;
    chk("R5 recovery pulse", pcount - p0, 1);
    check_all("R5 recovery");

    // R3 data rise and clock fall in the same cycle still latch
    p0 = pcount;
    send(16'hC0A5, 16, 1, 1);
    shadow[3] = 14'h00A5;
    chk("R3 same-cycle pulse", pcount - p0, 1);
    chk("R3 same-cycle target", int'(plast), 8);
    check_all("R3 same-cycle");

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule